// File: doc/BRIEF.md
# Scan Slice Expander

This block widens a narrow tester feed into the broad parallel input of a set of scan chains. A tester offers a small word (CHANS bits) each cycle; the block keeps a full-width slice register (CHAINS bits, CHAINS > CHANS) whose content drives the chain inputs. A new slice is produced either by folding one tester word into the previous slice with XOR (add mode, one word per slice) or by streaming the whole slice in raw over CHAINS/CHANS words (shift mode). The chains advance exactly once per finished slice.

The tester presents `mode_in` together with the first word of every slice; that one sample fixes how the slice is built. The very first slice after reset has no predecessor to add to, so it is always streamed in raw. A controller with four named states steers the datapath: `ST_IDLE` (no slice built yet since reset), `ST_WAIT` (a slice is held, next one not started), `ST_LOAD` (a raw slice is partially streamed in) and `ST_EMIT` (a slice has just completed; chain strobe high). Transitions: `ST_IDLE`→`ST_LOAD` on the first accepted word; `ST_WAIT`/`ST_EMIT`→`ST_LOAD` on a word with mode 1; `ST_WAIT`/`ST_EMIT`→`ST_EMIT` on a word with mode 0; `ST_LOAD`→`ST_EMIT` on the last streamed word; `ST_LOAD`→`ST_LOAD` otherwise; `ST_EMIT`→`ST_WAIT` when no word arrives. A word is accepted in a cycle where `tester_valid` and `ready` are both high.

Top module: `scan_slice_expander`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears `slice_out` to all zeros, drops `chain_strobe`, `slice_valid`, `scan_en` and `ready` to 0, and returns the controller to `ST_IDLE`; `ready` rises after the first edge with `rst` low.
- R2: An accepted word with `mode_in` = 0 while a slice is held gives, one cycle later, `slice_out` equal to the previous `slice_out` XOR the spread of the word, with `chain_strobe` high in that cycle.
- R3: In the spread of a word, slice bit k takes channel bit k mod CHANS, so channel j toggles bits j, j+CHANS, j+2·CHANS and so on.
- R4: A shift-mode slice takes CHAINS/CHANS accepted words; word number w (counting from 0) ends up at slice bits w·CHANS to w·CHANS+CHANS-1 with channel j at bit w·CHANS+j, and the slice is emitted in the cycle after the last word is accepted.
- R5: The first slice after reset is built in shift mode whatever `mode_in` holds with its first word.
- R6: `chain_strobe` and `slice_valid` are high for exactly one cycle per finished slice and never while a shift-mode slice is incomplete.
- R7: In any cycle without an accepted word, `slice_out` is unchanged at the next edge and an incomplete shift-mode load keeps its word count.
- R8: `mode_in` is sampled only with the first word of a slice; its value during the remaining words of a shift-mode slice is ignored.
- R9: The first word of the next slice may be accepted in the cycle in which the previous slice is strobed, so add-mode slices can complete on every cycle.
- R10: `scan_en` is 0 from reset until the first word is accepted and 1 from the following cycle until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tester_valid | input | 1 | A tester word is presented |
| mode_in | input | 1 | Build mode of a slice, read with its first word: 1 shift, 0 add |
| chan_in | input | CHANS | Tester channel word |
| ready | output | 1 | Words are accepted when high |
| scan_en | output | 1 | Scan enable to the chains |
| chain_strobe | output | 1 | One-cycle shift pulse to the chains |
| slice_valid | output | 1 | Marks the cycle in which `slice_out` is a finished slice |
| slice_out | output | CHAINS | Current slice driven to the chain inputs |

## Verification
The strobe of a finished slice and the acceptance of the next slice's first word can fall in the same cycle, which is where an off-by-one in the controller would either drop a strobe or corrupt the slice being emitted. The bench provokes this with unbroken runs of add-mode codes (a new slice every cycle) and with shift-mode slices started directly in a strobe cycle, including a switch between the two modes at that boundary. A behavioural model rebuilds every slice from its own word queue or XOR rule and compares strobe, scan enable and the emitted slice on every clock, so a strobe lost, doubled or carrying a half-updated slice is reported.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_LOAD = 2'd2,
        ST_EMIT = 2'd3
    } ssx_state_e;

endpackage

// File: rtl/ssx_add_cells.sv
module ssx_add_cells #(
    parameter int CHAINS = 32,
    parameter int CHANS  = 8
) (
    input  logic [CHANS-1:0]  code,
    output logic [CHAINS-1:0] spread
);

    // Each slice bit is fed by the channel whose index equals the bit index
    // modulo the channel count: an even fan-out of every channel.
    for (genvar k = 0; k < CHAINS; k++) begin : g_cell
        assign spread[k] = code[k % CHANS];
    end

endmodule

// File: rtl/ssx_slice_reg.sv
module ssx_slice_reg #(
    parameter int CHAINS = 32,
    parameter int CHANS  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              do_shift,
    input  logic              do_add,
    input  logic [CHANS-1:0]  word,
    input  logic [CHAINS-1:0] spread,
    output logic [CHAINS-1:0] slice
);

    always_ff @(posedge clk) begin
        if (rst) begin
            slice <= '0;
        end else if (do_shift) begin
            // New word enters at the top and moves down one word per load.
            slice <= {word, slice[CHAINS-1:CHANS]};
        end else if (do_add) begin
            slice <= slice ^ spread;
        end
    end

endmodule

// File: rtl/ssx_ctrl.sv
module ssx_ctrl
    import ssx_pkg::*;
#(
    parameter int WORDS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  logic       mode_in,
    output logic       do_shift,
    output logic       do_add,
    output logic       scan_en,
    output logic       chain_strobe,
    output logic       slice_valid,
    output ssx_state_e state
);

    localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

    ssx_state_e    state_n;
    logic [CW-1:0] cnt, cnt_n;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Next state and datapath steering.
    always_comb begin
        state_n  = state;
        cnt_n    = cnt;
        do_shift = 1'b0;
        do_add   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    do_shift = 1'b1;
                    cnt_n    = CW'(1);
                    state_n  = ST_LOAD;
                end
            end
            ST_WAIT, ST_EMIT: begin
                if (accept) begin
                    if (mode_in) begin
                        do_shift = 1'b1;
                        cnt_n    = CW'(1);
                        state_n  = ST_LOAD;
                    end else begin
                        do_add  = 1'b1;
                        state_n = ST_EMIT;
                    end
                end else begin
                    state_n = ST_WAIT;
                end
            end
            ST_LOAD: begin
                if (accept) begin
                    do_shift = 1'b1;
                    if (cnt == LAST) begin
                        cnt_n   = '0;
                        state_n = ST_EMIT;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Moore outputs towards the chains.
    always_comb begin
        scan_en      = 1'b1;
        chain_strobe = 1'b0;
        slice_valid  = 1'b0;
        unique case (state)
            ST_IDLE: scan_en = 1'b0;
            ST_WAIT, ST_LOAD: ;
            ST_EMIT: begin
                chain_strobe = 1'b1;
                slice_valid  = 1'b1;
            end
            default: scan_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/scan_slice_expander.sv
module scan_slice_expander
    import ssx_pkg::*;
#(
    parameter int CHAINS = 32,
    parameter int CHANS  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tester_valid,
    input  logic              mode_in,
    input  logic [CHANS-1:0]  chan_in,
    output logic              ready,
    output logic              scan_en,
    output logic              chain_strobe,
    output logic              slice_valid,
    output logic [CHAINS-1:0] slice_out
);

    localparam int WORDS = CHAINS / CHANS;

    ssx_state_e        fsm_state;
    logic              accept;
    logic              do_shift, do_add;
    logic [CHAINS-1:0] spread;

    always_ff @(posedge clk) begin
        if (rst) ready <= 1'b0;
        else     ready <= 1'b1;
    end

    assign accept = tester_valid && ready;

    ssx_ctrl #(.WORDS(WORDS)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .accept       (accept),
        .mode_in      (mode_in),
        .do_shift     (do_shift),
        .do_add       (do_add),
        .scan_en      (scan_en),
        .chain_strobe (chain_strobe),
        .slice_valid  (slice_valid),
        .state        (fsm_state)
    );

    ssx_add_cells #(.CHAINS(CHAINS), .CHANS(CHANS)) u_add (
        .code   (chan_in),
        .spread (spread)
    );

    ssx_slice_reg #(.CHAINS(CHAINS), .CHANS(CHANS)) u_slice (
        .clk      (clk),
        .rst      (rst),
        .do_shift (do_shift),
        .do_add   (do_add),
        .word     (chan_in),
        .spread   (spread),
        .slice    (slice_out)
    );

endmodule

// File: rtl/ssx_checker.sv
module ssx_checker
    import ssx_pkg::*;
#(
    parameter int CHAINS = 32,
    parameter int CHANS  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tester_valid,
    input logic              mode_in,
    input logic [CHANS-1:0]  chan_in,
    input logic              ready,
    input logic              scan_en,
    input logic              chain_strobe,
    input logic              slice_valid,
    input logic [CHAINS-1:0] slice_out,
    input ssx_state_e        fsm_state
);

    function automatic logic [CHAINS-1:0] fan(input logic [CHANS-1:0] c);
        logic [CHAINS-1:0] r;
        for (int k = 0; k < CHAINS; k++) r[k] = c[k % CHANS];
        return r;
    endfunction

    logic took;
    assign took = tester_valid && ready;

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (slice_out == '0 && !chain_strobe && !slice_valid && !ready && !scan_en));

    // R2, R3
    p_add_fold_r2: assert property (@(posedge clk) disable iff (rst)
        (took && !mode_in && (fsm_state == ST_WAIT || fsm_state == ST_EMIT))
        |=> (chain_strobe && slice_out == ($past(slice_out) ^ fan($past(chan_in)))));

    // R5
    p_first_shift_r5: assert property (@(posedge clk) disable iff (rst)
        (took && fsm_state == ST_IDLE) |=> !chain_strobe);

    // R6
    p_strobe_after_word_r6: assert property (@(posedge clk) disable iff (rst)
        chain_strobe |-> $past(took));

    // R7
    p_hold_slice_r7: assert property (@(posedge clk) disable iff (rst)
        !took |=> $stable(slice_out));

    // R6, R7
    p_gap_no_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == ST_LOAD && !took) |=> !chain_strobe);

    // R10
    p_scan_en_r10: assert property (@(posedge clk) disable iff (rst)
        (chain_strobe || fsm_state == ST_LOAD) |-> scan_en);

endmodule

bind scan_slice_expander ssx_checker #(.CHAINS(CHAINS), .CHANS(CHANS)) u_ssx_checker (
    .clk          (clk),
    .rst          (rst),
    .tester_valid (tester_valid),
    .mode_in      (mode_in),
    .chan_in      (chan_in),
    .ready        (ready),
    .scan_en      (scan_en),
    .chain_strobe (chain_strobe),
    .slice_valid  (slice_valid),
    .slice_out    (slice_out),
    .fsm_state    (fsm_state)
);

// File: tb/test_scan_slice_expander.sv
`timescale 1ns/1ps
module test_scan_slice_expander;

    localparam int CHAINS = 32;
    localparam int CHANS  = 8;
    localparam int WORDS  = CHAINS / CHANS;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tester_valid = 1'b0;
    logic              mode_in = 1'b0;
    logic [CHANS-1:0]  chan_in = '0;
    logic              ready, scan_en, chain_strobe, slice_valid;
    logic [CHAINS-1:0] slice_out;

    always #2 clk = ~clk;

    scan_slice_expander #(.CHAINS(CHAINS), .CHANS(CHANS)) i_scan_slice_expander (
        .clk(clk), .rst(rst), .tester_valid(tester_valid), .mode_in(mode_in),
        .chan_in(chan_in), .ready(ready), .scan_en(scan_en),
        .chain_strobe(chain_strobe), .slice_valid(slice_valid), .slice_out(slice_out)
    );

    // Behavioural reference state
    int                n_run = 0, n_fail = 0;
    bit                done = 0;
    logic [CHAINS-1:0] m_slice;
    logic [CHANS-1:0]  m_q[$];
    bit                m_ready, m_started, m_loading, m_strobe;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [CHAINS-1:0] act, input logic [CHAINS-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic m_reset();
        m_slice = '0; m_q.delete();
        m_ready = 0; m_started = 0; m_loading = 0; m_strobe = 0;
    endtask

    task automatic compare(input string tag);
        chk(chain_strobe === m_strobe, "R6", "chain_strobe", 32'(chain_strobe), 32'(m_strobe));
        chk(slice_valid === m_strobe, "R6", "slice_valid", 32'(slice_valid), 32'(m_strobe));
        chk(scan_en === m_started, "R10", "scan_en", 32'(scan_en), 32'(m_started));
        chk(ready === m_ready, "R1", "ready", 32'(ready), 32'(m_ready));
        if (m_strobe)
            chk(slice_out === m_slice, tag, "emitted slice", slice_out, m_slice);
        else if (m_started && !m_loading)
            chk(slice_out === m_slice, "R7", "held slice", slice_out, m_slice);
    endtask

    task automatic step(input bit v, input bit m, input logic [CHANS-1:0] w, input string tag);
        bit acc;
        tester_valid = v; mode_in = m; chan_in = w; rst = 1'b0;
        @(posedge clk);
        acc = v && m_ready;
        m_ready = 1;
        m_strobe = 0;
        if (acc) begin
            if (m_loading) begin
                m_q.push_back(w);
            end else if (!m_started || m) begin
                m_loading = 1;
                m_q.delete();
                m_q.push_back(w);
            end else begin
                for (int k = 0; k < CHAINS; k++) m_slice[k] = m_slice[k] ^ w[k % CHANS];
                m_strobe = 1;
            end
            m_started = 1;
            if (m_loading && m_q.size() == WORDS) begin
                for (int k = 0; k < CHAINS; k++) m_slice[k] = m_q[k / CHANS][k % CHANS];
                m_loading = 0;
                m_strobe = 1;
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(input int n);
        tester_valid = 0; rst = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            m_reset();
            @(negedge clk);
            chk(slice_out === '0, "R1", "slice after reset", slice_out, '0);
            chk(!chain_strobe && !slice_valid && !scan_en && !ready, "R1", "controls in reset",
                {28'd0, chain_strobe, slice_valid, scan_en, ready}, '0);
        end
    endtask

    task automatic shift_slice(input logic [CHAINS-1:0] s, input bit first_mode, input string tag);
        for (int w = 0; w < WORDS; w++)
            step(1'b1, (w == 0) ? first_mode : ~w[0], s[w*CHANS +: CHANS], tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        m_reset();
        @(negedge clk);
        do_reset(3);                                    // R1
        step(0, 0, 8'h00, "R10");                       // ready rises, scan_en still low
        // R5: first slice with mode 0 must still stream; R8: mode toggles on later words
        shift_slice(32'hA1B2C3D4, 1'b0, "R5");
        // R2/R3/R9: unbroken add run, single-channel codes included
        step(1, 0, 8'h01, "R3");
        step(1, 0, 8'h80, "R3");
        step(1, 0, 8'h5A, "R2");
        step(1, 0, 8'hFF, "R9");
        step(1, 0, 8'h00, "R9");
        step(1, 0, 8'h3C, "R2");
        // R7: gaps while holding
        repeat (3) step(0, 1, 8'hEE, "R7");
        // R4/R7: raw slice with gaps between words
        step(1, 1, 8'h11, "R4");
        step(0, 0, 8'h99, "R7");
        step(1, 0, 8'h22, "R8");
        step(0, 1, 8'h77, "R7");
        step(0, 1, 8'h66, "R7");
        step(1, 0, 8'h33, "R8");
        step(1, 1, 8'h44, "R4");
        // R4/R9: back-to-back raw slices started in the strobe cycle
        shift_slice(32'hDEADBEEF, 1'b1, "R4");
        shift_slice(32'h0F1E2D3C, 1'b1, "R9");
        // R9: add directly after raw, then raw directly after add
        step(1, 0, 8'hC3, "R9");
        shift_slice(32'h12345678, 1'b1, "R9");
        step(0, 0, 8'h00, "R7");
        step(1, 0, 8'h0F, "R2");
        // R1: reset in the middle of a load, R5 again afterwards
        step(1, 1, 8'hAA, "R4");
        step(1, 1, 8'hBB, "R4");
        do_reset(2);
        step(0, 0, 8'h00, "R10");
        shift_slice(32'h55AA33CC, 1'b0, "R5");
        step(1, 0, 8'h81, "R2");
        repeat (2) step(0, 0, 8'h00, "R7");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule